// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block steers a five-stage in-order pipeline: fetch, decode, address calculate, execute and writeback. Each cycle the fetch unit presents a small descriptor for the instruction it is reading. The descriptor says whether the slot is valid, whether it is a jump and how that jump will resolve, which register it writes, and which base, index or implicit stack-pointer reads its address calculation needs. The controller carries these descriptors down its own stage registers. From them it drives the advance, bubble, flush and redirect controls that the datapath stages obey.

Control flow is predicted not taken. Fetch keeps reading sequentially past a jump. When a jump reaches execute and resolves taken, the two younger slots in decode and address calculate are discarded. In the same cycle fetch is redirected, so the target is read at once. Address-generation interlocks are detected between address calculate and execute only. The interlock inserts one empty slot into execute and holds the three front stages.

Top module: `hazard_ctl`

## Requirements
- R1: While reset is asserted and directly after it, no slot is valid: `wb_vld`, `redirect`, `stall_ac` and `bub_ex` are 0 and `adv_front` is 1.
- R2: With no hazards, one instruction enters per cycle. An instruction presented at fetch in cycle k shows `wb_vld` with its id four clock edges later. Eight independent instructions therefore finish within 12 cycles, counting the first fetch cycle.
- R3: The interlock fires in one case. The slot in address calculate reads a base register (enable plus index) or an index register, and that register equals the destination of the valid slot in execute. Then `stall_ac` is 1 for exactly one cycle, execute receives an empty slot, and fetch, decode and address calculate hold (`adv_front` = 0). The dependent instruction retires one cycle late.
- R4: Stack-pointer traffic counts as a dependency. A slot flagged as reading the stack pointer interlocks against an execute slot that either is flagged as writing it implicitly or names register index SP_REG (default 4) as its destination.
- R5: Dependencies are checked only between adjacent slots. A producer that is two or more slots ahead of the consumer causes no stall.
- R6: A jump flagged not taken costs no cycle and never raises `redirect`.
- R7: A valid jump flagged taken raises `redirect`, `flush_de` and `flush_ac` in the cycle it occupies execute. Fetch takes the target in that same cycle, so the target retires three cycles after the jump. The two wrong-path instructions never appear at writeback.
- R8: When a taken jump in execute and an interlock condition occur in the same cycle, the flush wins: `stall_ac` stays 0 and `redirect` is 1.
- R9: A slot with valid = 0 never retires, never redirects fetch and never raises an interlock, whatever register fields it carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| f_vld | input | 1 | Fetch slot holds an instruction |
| f_id | input | ID_W | Tag of the fetched instruction |
| f_jmp | input | 1 | Fetched instruction is a jump |
| f_tkn | input | 1 | That jump will resolve taken |
| f_dst_en | input | 1 | Instruction writes a register |
| f_dst | input | REG_W | Destination register index |
| f_base_en | input | 1 | Address uses a base register |
| f_base | input | REG_W | Base register index |
| f_idx_en | input | 1 | Address uses an index register |
| f_idx | input | REG_W | Index register index |
| f_sp_rd | input | 1 | Implicitly reads the stack pointer |
| f_sp_wr | input | 1 | Implicitly writes the stack pointer |
| adv_front | output | 1 | Fetch, decode and address calculate advance; the fetch descriptor is accepted |
| bub_ex | output | 1 | Execute is loaded with an empty slot |
| flush_de | output | 1 | Decode contents are discarded |
| flush_ac | output | 1 | Address-calculate contents are discarded |
| redirect | output | 1 | Fetch must read from the jump target this cycle |
| stall_ac | output | 1 | Address-generation interlock active |
| wb_vld | output | 1 | A valid instruction is in writeback |
| wb_id | output | ID_W | Tag of that instruction |

## Verification
The two functions that can meet in one cycle are the taken-jump flush and the address-generation interlock. They meet when a call, which is a taken jump that implicitly writes the stack pointer, sits in execute while a pop that reads the stack pointer sits in address calculate behind it. The bench builds exactly that program. It checks that the cycle shows a redirect with no stall, and that the target retires three cycles after the call with no extra delay. The pop must never retire.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int REG_W  = 4,
  parameter int ID_W   = 6,
  parameter int SP_REG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_vld,
  input  logic [ID_W-1:0]  f_id,
  input  logic             f_jmp,
  input  logic             f_tkn,
  input  logic             f_dst_en,
  input  logic [REG_W-1:0] f_dst,
  input  logic             f_base_en,
  input  logic [REG_W-1:0] f_base,
  input  logic             f_idx_en,
  input  logic [REG_W-1:0] f_idx,
  input  logic             f_sp_rd,
  input  logic             f_sp_wr,
  output logic             adv_front,
  output logic             bub_ex,
  output logic             flush_de,
  output logic             flush_ac,
  output logic             redirect,
  output logic             stall_ac,
  output logic             wb_vld,
  output logic [ID_W-1:0]  wb_id
);

  localparam logic [REG_W-1:0] SP_IDX = REG_W'(SP_REG);

  typedef struct packed {
    logic             vld;
    logic [ID_W-1:0]  id;
    logic             jmp;
    logic             tkn;
    logic             dst_en;
    logic [REG_W-1:0] dst;
    logic             b_en;
    logic [REG_W-1:0] base;
    logic             i_en;
    logic [REG_W-1:0] idx;
    logic             sp_rd;
    logic             sp_wr;
  } slot_t;

  slot_t f_s, de_q, ac_q, ex_q;
  logic  wb_vld_q;
  logic [ID_W-1:0] wb_id_q;

  assign f_s = '{vld: f_vld, id: f_id, jmp: f_jmp, tkn: f_tkn,
                 dst_en: f_dst_en, dst: f_dst, b_en: f_base_en, base: f_base,
                 i_en: f_idx_en, idx: f_idx, sp_rd: f_sp_rd, sp_wr: f_sp_wr};

  logic ex_wr, ex_wr_sp, hit_base, hit_idx, hit_sp, flush, stall;

  assign ex_wr    = ex_q.vld & ex_q.dst_en;
  assign ex_wr_sp = ex_q.vld & (ex_q.sp_wr | (ex_q.dst_en & (ex_q.dst == SP_IDX)));
  assign hit_base = ac_q.b_en & ex_wr & (ac_q.base == ex_q.dst);
  assign hit_idx  = ac_q.i_en & ex_wr & (ac_q.idx == ex_q.dst);
  assign hit_sp   = ac_q.sp_rd & ex_wr_sp;

  assign flush = ex_q.vld & ex_q.jmp & ex_q.tkn;
  assign stall = ~flush & ac_q.vld & (hit_base | hit_idx | hit_sp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q     <= '0;
      ac_q     <= '0;
      ex_q     <= '0;
      wb_vld_q <= 1'b0;
      wb_id_q  <= '0;
    end else begin
      wb_vld_q <= ex_q.vld;
      wb_id_q  <= ex_q.id;
      ex_q     <= (stall | flush) ? '0 : ac_q;
      ac_q     <= flush ? '0 : (stall ? ac_q : de_q);
      de_q     <= stall ? de_q : f_s;
    end
  end

  assign adv_front = ~stall;
  assign bub_ex    = stall | flush;
  assign flush_de  = flush;
  assign flush_ac  = flush;
  assign redirect  = flush;
  assign stall_ac  = stall;
  assign wb_vld    = wb_vld_q;
  assign wb_id     = wb_id_q;

endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic adv_front,
  input logic redirect,
  input logic stall_ac,
  input logic wb_vld
);

  assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect && stall_ac));

  assert_stall_holds_front_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ac |-> !adv_front);

  assert_one_slot_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ac |=> !stall_ac);

  assert_stall_bubble_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ac |=> ##1 !wb_vld);

  assert_redirect_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  assert_flushed_slot_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> ##1 !wb_vld);

endmodule

bind hazard_ctl hazard_ctl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .adv_front (adv_front),
  .redirect  (redirect),
  .stall_ac  (stall_ac),
  .wb_vld    (wb_vld)
);

// File: tb/hazard_ctl_tb_top.sv
`timescale 1ns/1ps
module hazard_ctl_tb_top;

  localparam int REG_W = 4;
  localparam int ID_W  = 6;
  localparam int NP    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic vld, jmp, tkn, dst_en;
    logic [REG_W-1:0] dst;
    logic b_en;
    logic [REG_W-1:0] base;
    logic i_en;
    logic [REG_W-1:0] idx;
    logic sp_rd, sp_wr;
    int   tgt;
  } ins_t;

  ins_t prog [NP];
  int   plen = 0;
  int   pc = 0, tgt_q = 0, cur;

  logic f_vld, f_jmp, f_tkn, f_dst_en, f_base_en, f_idx_en, f_sp_rd, f_sp_wr;
  logic [ID_W-1:0]  f_id;
  logic [REG_W-1:0] f_dst, f_base, f_idx;
  logic adv_front, bub_ex, flush_de, flush_ac, redirect, stall_ac, wb_vld;
  logic [ID_W-1:0] wb_id;

  hazard_ctl #(.REG_W(REG_W), .ID_W(ID_W), .SP_REG(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .f_vld(f_vld), .f_id(f_id), .f_jmp(f_jmp), .f_tkn(f_tkn),
    .f_dst_en(f_dst_en), .f_dst(f_dst), .f_base_en(f_base_en), .f_base(f_base),
    .f_idx_en(f_idx_en), .f_idx(f_idx), .f_sp_rd(f_sp_rd), .f_sp_wr(f_sp_wr),
    .adv_front(adv_front), .bub_ex(bub_ex), .flush_de(flush_de), .flush_ac(flush_ac),
    .redirect(redirect), .stall_ac(stall_ac), .wb_vld(wb_vld), .wb_id(wb_id)
  );

  // fetch model: instruction memory indexed by pc, target on redirect
  always_comb begin
    cur = redirect ? tgt_q : pc;
    f_vld = 1'b0; f_id = ID_W'(cur); f_jmp = 1'b0; f_tkn = 1'b0;
    f_dst_en = 1'b0; f_dst = '0; f_base_en = 1'b0; f_base = '0;
    f_idx_en = 1'b0; f_idx = '0; f_sp_rd = 1'b0; f_sp_wr = 1'b0;
    if (cur < plen) begin
      f_vld = prog[cur].vld;   f_jmp = prog[cur].jmp;   f_tkn = prog[cur].tkn;
      f_dst_en = prog[cur].dst_en; f_dst = prog[cur].dst;
      f_base_en = prog[cur].b_en;  f_base = prog[cur].base;
      f_idx_en = prog[cur].i_en;   f_idx = prog[cur].idx;
      f_sp_rd = prog[cur].sp_rd;   f_sp_wr = prog[cur].sp_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= 0;
    end else if (adv_front) begin
      pc <= cur + 1;
      if (cur < plen && prog[cur].jmp && prog[cur].tkn) tgt_q <= prog[cur].tgt;
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int seen [64];
  int n_stall, n_redir, n_both;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_vld) seen[wb_id] = cyc;
      if (stall_ac) n_stall++;
      if (redirect) n_redir++;
      if (stall_ac && redirect) n_both++;
    end
  end

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic new_prog(int n);
    for (int i = 0; i < NP; i++) prog[i] = '{vld: 1'b1, default: 0};
    plen = n;
  endtask

  int s0;
  task automatic run(int ncyc);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) seen[i] = -1;
    n_stall = 0; n_redir = 0; n_both = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    s0 = cyc;
    repeat (ncyc) @(negedge clk);
  endtask

  function automatic int rel(int id);
    return (seen[id] < 0) ? -1 : seen[id] - s0;
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "wb_vld in reset", wb_vld, 0);
    chk("R1", "redirect in reset", redirect, 0);
    chk("R1", "stall_ac in reset", stall_ac, 0);
    chk("R1", "bub_ex in reset", bub_ex, 0);
    chk("R1", "adv_front in reset", adv_front, 1);
  endtask

  task automatic t_stream;
    new_prog(8);
    run(16);
    for (int i = 0; i < 8; i++) chk("R2", $sformatf("retire edge id%0d", i), rel(i), 4 + i);
    chk("R2", "total cycles for 8", rel(7) + 1, 12);
    chk("R2", "no stall", n_stall, 0);
  endtask

  task automatic t_agi_base;
    new_prog(4);
    prog[0].dst_en = 1; prog[0].dst = 2;
    prog[1].b_en = 1;   prog[1].base = 2;
    run(14);
    chk("R3", "base: id0", rel(0), 4);
    chk("R3", "base: id1 delayed", rel(1), 6);
    chk("R3", "base: id3", rel(3), 8);
    chk("R3", "base: stall cycles", n_stall, 1);
  endtask

  task automatic t_agi_idx;
    new_prog(4);
    prog[0].dst_en = 1; prog[0].dst = 7;
    prog[1].i_en = 1;   prog[1].idx = 7;
    prog[1].b_en = 1;   prog[1].base = 3;
    run(14);
    chk("R3", "index: id1 delayed", rel(1), 6);
    chk("R3", "index: id2", rel(2), 7);
    chk("R3", "index: stall cycles", n_stall, 1);
  endtask

  task automatic t_sp;
    new_prog(4);
    prog[0].sp_wr = 1;
    prog[1].sp_rd = 1;
    prog[2].dst_en = 1; prog[2].dst = 4;
    prog[3].sp_rd = 1;
    run(16);
    chk("R4", "push->pop: id1", rel(1), 6);
    chk("R4", "push->pop: id2", rel(2), 7);
    chk("R4", "write SP->pop: id3", rel(3), 9);
    chk("R4", "stall cycles", n_stall, 2);
  endtask

  task automatic t_far;
    new_prog(4);
    prog[0].dst_en = 1; prog[0].dst = 2;
    prog[2].b_en = 1;   prog[2].base = 2;
    run(14);
    chk("R5", "two apart: id2", rel(2), 6);
    chk("R5", "two apart: id3", rel(3), 7);
    chk("R5", "no stall", n_stall, 0);
  endtask

  task automatic t_nt_jump;
    new_prog(4);
    prog[0].jmp = 1; prog[0].tkn = 0;
    run(14);
    chk("R6", "not taken: id1", rel(1), 5);
    chk("R6", "not taken: id3", rel(3), 7);
    chk("R6", "no redirect", n_redir, 0);
  endtask

  task automatic t_taken;
    new_prog(7);
    prog[0].jmp = 1; prog[0].tkn = 1; prog[0].tgt = 5;
    run(16);
    chk("R7", "jump retires", rel(0), 4);
    chk("R7", "target retires", rel(5), 7);
    chk("R7", "target+1 retires", rel(6), 8);
    chk("R7", "wrong path id1", rel(1), -1);
    chk("R7", "wrong path id2", rel(2), -1);
    chk("R7", "never fetched id3", rel(3), -1);
    chk("R7", "redirect count", n_redir, 1);
  endtask

  task automatic t_prio;
    new_prog(5);
    prog[0].jmp = 1; prog[0].tkn = 1; prog[0].tgt = 3; prog[0].sp_wr = 1;
    prog[1].sp_rd = 1;
    run(16);
    chk("R8", "stall and redirect together", n_both, 0);
    chk("R8", "no stall", n_stall, 0);
    chk("R8", "target retires", rel(3), 7);
    chk("R8", "next retires", rel(4), 8);
    chk("R8", "flushed pop", rel(1), -1);
  endtask

  task automatic t_gap;
    new_prog(3);
    prog[0].dst_en = 1; prog[0].dst = 3;
    prog[1].vld = 0; prog[1].b_en = 1; prog[1].base = 3; prog[1].jmp = 1; prog[1].tkn = 1;
    prog[2].b_en = 1; prog[2].base = 3;
    run(14);
    chk("R9", "empty slot not retired", rel(1), -1);
    chk("R9", "no interlock from empty slot", n_stall, 0);
    chk("R9", "no redirect from empty slot", n_redir, 0);
    chk("R9", "id2 on time", rel(2), 6);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    t_reset();
    t_stream();
    t_agi_base();
    t_agi_idx();
    t_sp();
    t_far();
    t_nt_jump();
    t_taken();
    t_prio();
    t_gap();
    summary();
  end

endmodule